// File: doc/BRIEF.md
# Serial ADC conversion-frame controller

This block is the master side of a link to a two-channel, 16-bit successive-approximation converter with two serial result outputs. It divides the system clock into a free-running serial clock. Once per frame it raises a start strobe, which the converter also uses as its read strobe. During the first bit periods of the frame it drives the channel-address line. It then shifts in the returned bits on falling serial-clock edges. The two leading address/channel bits are stripped off and become a tag. The 16 sample bits that follow are presented on a held valid/ready output.

One output line or both lines can be read. Four modes are selected by a 2-bit configuration that the block copies onto its mode-select outputs at each frame start:

| Code | Lines read | Channel behaviour | Frame period |
|------|------------|-------------------|--------------|
| 0 | A and B | fixed channel | 33 serial periods |
| 1 | A and B | alternating | 33 serial periods |
| 2 | A only | two channels | 21 serial periods |
| 3 | A only | four-channel sequence | 21 serial periods |

In mode 3 the first frame after the mode is entered is discarded, so the first delivered word belongs to the first channel of the sequence. Dropping the enable lets the running frame complete before the clock and strobe go idle.

Top module: `adc_frame_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, sclk_o, conv_strobe_o, addr_o, smp_valid_o and ovr_o are low and mode_o is 0.
- R2: With an effective divider d (d = div_sel, or 1 when div_sel is 0), each serial-clock period lasts d+1 system cycles. Of these, sclk_o is high for (d+1)/2 cycles (integer division), beginning at the rising edge.
- R3: conv_strobe_o rises on the same system edge as an sclk_o rise. It stays high for exactly 3 serial periods, numbered 0, 1 and 2 of the frame.
- R4: A frame lasts 21 serial periods in the single-line modes (mode 2 or 3) and 33 in the two-line modes (mode 0 or 1).
- R5: addr_o is high in serial periods 0 to 3 of a frame when chan_sel was 1 at the sclk_o rise that opened that period; otherwise addr_o is low.
- R6: Line A is sampled at each sclk_o fall. The bit sampled in serial period k+1 is received bit k. Bits 0 and 1 form tag_a_o, with bit 0 as its MSB, and bits 2 to 17 form smp_a_o, MSB first. smp_valid_o rises on the sclk_o fall of period 18.
- R7: In the two-line modes, line B is captured on the same edges into smp_b_o/tag_b_o with the same bit positions. In the single-line modes, smp_b_o and tag_b_o are zero.
- R8: In mode 3, the frame that starts from idle, or whose start first changes mode_o to 3, produces no sample. Later frames do produce samples.
- R9: A sample stays on the outputs with smp_valid_o high until smp_ready_i is seen high. A new sample arriving while the old one is held and not accepted replaces it and pulses ovr_o high for one cycle.
- R10: When en is low at the point a frame would start, no new frame begins. sclk_o and conv_strobe_o then stay low until en returns.
- R11: mode_o takes the value of cfg_mode at each frame start and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Framing enable |
| div_sel | input | DIV_W | Serial clock divider value (period = value+1) |
| cfg_mode | input | 2 | Requested converter mode |
| chan_sel | input | 1 | Channel to address (0 or 1) |
| sdo_a | input | 1 | Serial result line A |
| sdo_b | input | 1 | Serial result line B |
| sclk_o | output | 1 | Serial conversion clock |
| conv_strobe_o | output | 1 | Conversion start / read strobe |
| addr_o | output | 1 | Channel address line |
| mode_o | output | 2 | Mode-select lines |
| smp_valid_o | output | 1 | Sample valid |
| smp_ready_i | input | 1 | Consumer ready |
| smp_a_o | output | SMP_W | Sample from line A |
| tag_a_o | output | TAG_W | Address/channel tag from line A |
| smp_b_o | output | SMP_W | Sample from line B |
| tag_b_o | output | TAG_W | Address/channel tag from line B |
| ovr_o | output | 1 | Overrun pulse |

## Verification
The bench uses an odd divider (uneven duty), a zero divider (clamped to 1) and a divide-by-4 setting. A design that mishandles the half-period would shift every falling-edge capture. A misplaced one-bit delay would present tag and sample bits rotated by one. The bench alternates between 21- and 33-period frames and restarts four-channel mode from idle. A frame counter that is off by one would show up as a stretched strobe, and a missing discard would leak the first-frame word. A withheld ready across three frames must give exactly two overruns, each with a replaced sample. The enable is also dropped mid-frame: a controller that cut the frame short would lose that frame's sample, and one that ignored the enable would keep clocking.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL_FIX = 2'd0,
    MODE_DUAL_ALT = 2'd1,
    MODE_SGL_TWO  = 2'd2,
    MODE_SGL_SEQ  = 2'd3
  } adcf_mode_e;
endpackage

// File: rtl/adcf_clkdiv.sv
module adcf_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] ph_q, d_eff, half_m1;
  logic [DIV_W:0]   d_ext;

  always_comb begin
    d_eff   = (div_sel == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : div_sel;
    d_ext   = {1'b0, d_eff} + {{DIV_W{1'b0}}, 1'b1};
    half_m1 = d_ext[DIV_W:1] - {{(DIV_W-1){1'b0}}, 1'b1};
    rise_o  = run && (ph_q == d_eff);
    fall_o  = run && (ph_q == half_m1);
  end

  always_ff @(posedge clk) begin
    if (rst)       ph_q <= '0;
    else if (load) ph_q <= d_eff;
    else if (run)  ph_q <= rise_o ? '0 : ph_q + 1'b1;
  end
endmodule

// File: rtl/adcf_seq.sv
module adcf_seq #(
  parameter int FRAME_S  = 20,
  parameter int FRAME_D  = 32,
  parameter int STRB_LEN = 3,
  parameter int ADDR_LEN = 4,
  parameter int CAP_BITS = 18,
  parameter int BIT_W    = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] cfg_mode,
  input  logic       chan_sel,
  input  logic       rise,
  input  logic       fall,
  output logic       load_o,
  output logic       run_o,
  output logic       sclk_o,
  output logic       strb_o,
  output logic       addr_o,
  output logic [1:0] mode_o,
  output logic       shift_o,
  output logic       emit_o
);
  import adcf_pkg::*;
  localparam logic [BIT_W-1:0] FB_S = BIT_W'(FRAME_S);
  localparam logic [BIT_W-1:0] FB_D = BIT_W'(FRAME_D);
  localparam logic [BIT_W-1:0] SL   = BIT_W'(STRB_LEN);
  localparam logic [BIT_W-1:0] AL   = BIT_W'(ADDR_LEN);
  localparam logic [BIT_W-1:0] CB   = BIT_W'(CAP_BITS);
  localparam logic [BIT_W-1:0] ONE  = BIT_W'(1);

  logic             run_q, fresh_q, skip_q;
  logic [BIT_W-1:0] bitc_q, bitc_n, fb;
  logic             wrap, stop, go, skip_n;

  always_comb begin
    fb      = mode_o[1] ? FB_S : FB_D;
    wrap    = fresh_q || (bitc_q == fb);
    stop    = rise && wrap && !en;
    go      = rise && !stop;
    bitc_n  = wrap ? '0 : bitc_q + ONE;
    skip_n  = (cfg_mode == MODE_SGL_SEQ) && (fresh_q || (cfg_mode != mode_o));
    load_o  = !run_q && en;
    shift_o = fall && (bitc_q >= ONE) && (bitc_q <= CB);
    emit_o  = fall && (bitc_q == CB) && !skip_q;
    run_o   = run_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0; fresh_q <= 1'b0; skip_q <= 1'b0; bitc_q <= '0;
      sclk_o <= 1'b0; strb_o <= 1'b0; addr_o <= 1'b0; mode_o <= 2'd0;
    end else begin
      if (load_o) begin
        run_q   <= 1'b1;
        fresh_q <= 1'b1;
      end
      if (stop) run_q <= 1'b0;
      if (go) begin
        sclk_o  <= 1'b1;
        bitc_q  <= bitc_n;
        strb_o  <= bitc_n < SL;
        addr_o  <= chan_sel && (bitc_n < AL);
        fresh_q <= 1'b0;
        if (wrap) begin
          mode_o <= cfg_mode;
          skip_q <= skip_n;
        end
      end
      if (fall) sclk_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adcf_rxlane.sv
module adcf_rxlane #(
  parameter int CAP_BITS = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift,
  input  logic                sdi,
  output logic [CAP_BITS-1:0] word_o
);
  logic [CAP_BITS-1:0] sh_q;

  assign word_o = {sh_q[CAP_BITS-2:0], sdi};

  always_ff @(posedge clk) begin
    if (rst)        sh_q <= '0;
    else if (shift) sh_q <= word_o;
  end
endmodule

// File: rtl/adcf_outreg.sv
module adcf_outreg #(
  parameter int SMP_W = 16,
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             emit,
  input  logic             ready,
  input  logic [SMP_W-1:0] a_smp,
  input  logic [TAG_W-1:0] a_tag,
  input  logic [SMP_W-1:0] b_smp,
  input  logic [TAG_W-1:0] b_tag,
  output logic             valid_o,
  output logic [SMP_W-1:0] a_smp_o,
  output logic [TAG_W-1:0] a_tag_o,
  output logic [SMP_W-1:0] b_smp_o,
  output logic [TAG_W-1:0] b_tag_o,
  output logic             ovr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0; ovr_o <= 1'b0;
      a_smp_o <= '0; a_tag_o <= '0; b_smp_o <= '0; b_tag_o <= '0;
    end else if (emit) begin
      ovr_o   <= valid_o && !ready;
      valid_o <= 1'b1;
      a_smp_o <= a_smp; a_tag_o <= a_tag;
      b_smp_o <= b_smp; b_tag_o <= b_tag;
    end else begin
      ovr_o <= 1'b0;
      if (valid_o && ready) valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl #(
  parameter int DIV_W    = 8,
  parameter int SMP_W    = 16,
  parameter int TAG_W    = 2,
  parameter int FRAME_S  = 20,
  parameter int FRAME_D  = 32,
  parameter int STRB_LEN = 3,
  parameter int ADDR_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [1:0]       cfg_mode,
  input  logic             chan_sel,
  input  logic             sdo_a,
  input  logic             sdo_b,
  output logic             sclk_o,
  output logic             conv_strobe_o,
  output logic             addr_o,
  output logic [1:0]       mode_o,
  output logic             smp_valid_o,
  input  logic             smp_ready_i,
  output logic [SMP_W-1:0] smp_a_o,
  output logic [TAG_W-1:0] tag_a_o,
  output logic [SMP_W-1:0] smp_b_o,
  output logic [TAG_W-1:0] tag_b_o,
  output logic             ovr_o
);
  localparam int CAP_BITS = SMP_W + TAG_W;
  localparam int BIT_W    = $clog2(FRAME_D + 1);
  localparam int LANES    = 2;

  logic rise, fall, load, run, shift, emit, dual;
  logic [CAP_BITS-1:0] word [LANES];
  logic [LANES-1:0]    sdi;

  assign sdi  = {sdo_b, sdo_a};
  assign dual = !mode_o[1];

  adcf_clkdiv #(.DIV_W(DIV_W)) clkdiv_i (
    .clk(clk), .rst(rst), .load(load), .run(run), .div_sel(div_sel),
    .rise_o(rise), .fall_o(fall));

  adcf_seq #(.FRAME_S(FRAME_S), .FRAME_D(FRAME_D), .STRB_LEN(STRB_LEN),
             .ADDR_LEN(ADDR_LEN), .CAP_BITS(CAP_BITS), .BIT_W(BIT_W)) seq_i (
    .clk(clk), .rst(rst), .en(en), .cfg_mode(cfg_mode), .chan_sel(chan_sel),
    .rise(rise), .fall(fall), .load_o(load), .run_o(run), .sclk_o(sclk_o),
    .strb_o(conv_strobe_o), .addr_o(addr_o), .mode_o(mode_o),
    .shift_o(shift), .emit_o(emit));

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    adcf_rxlane #(.CAP_BITS(CAP_BITS)) lane_i (
      .clk(clk), .rst(rst), .shift(shift), .sdi(sdi[g]), .word_o(word[g]));
  end

  logic [CAP_BITS-1:0] b_word;
  assign b_word = dual ? word[1] : '0;

  adcf_outreg #(.SMP_W(SMP_W), .TAG_W(TAG_W)) out_i (
    .clk(clk), .rst(rst), .emit(emit), .ready(smp_ready_i),
    .a_smp(word[0][SMP_W-1:0]), .a_tag(word[0][CAP_BITS-1 -: TAG_W]),
    .b_smp(b_word[SMP_W-1:0]),  .b_tag(b_word[CAP_BITS-1 -: TAG_W]),
    .valid_o(smp_valid_o), .a_smp_o(smp_a_o), .a_tag_o(tag_a_o),
    .b_smp_o(smp_b_o), .b_tag_o(tag_b_o), .ovr_o(ovr_o));
endmodule

// File: rtl/adcf_chk.sv
module adcf_chk #(
  parameter int SMP_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sclk_o,
  input logic             conv_strobe_o,
  input logic [1:0]       mode_o,
  input logic             smp_valid_o,
  input logic             smp_ready_i,
  input logic [SMP_W-1:0] smp_a_o,
  input logic             ovr_o
);
  // R3: strobe starts on a serial clock rise
  a_r3_strobe_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_strobe_o) |-> $rose(sclk_o));
  // R3: strobe ends on a serial clock rise
  a_r3_strobe_end_on_rise: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_strobe_o) |-> $rose(sclk_o));
  // R6: a fresh sample appears on a falling serial edge
  a_r6_valid_on_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(smp_valid_o) |-> $fell(sclk_o));
  // R9: an unaccepted sample is held
  a_r9_hold_valid: assert property (@(posedge clk) disable iff (rst)
    (smp_valid_o && !smp_ready_i) |=> smp_valid_o);
  // R9: held data changes only with an overrun
  a_r9_hold_data: assert property (@(posedge clk) disable iff (rst)
    (smp_valid_o && !smp_ready_i) |=> (ovr_o || $stable(smp_a_o)));
  // R9: overrun only accompanies a present sample
  a_r9_ovr_with_valid: assert property (@(posedge clk) disable iff (rst)
    ovr_o |-> smp_valid_o);
  // R11: mode lines change only at frame start
  a_r11_mode_at_frame: assert property (@(posedge clk) disable iff (rst)
    !$rose(conv_strobe_o) |-> $stable(mode_o));
endmodule

bind adc_frame_ctrl adcf_chk #(.SMP_W(SMP_W)) chk_i (
  .clk(clk), .rst(rst), .sclk_o(sclk_o), .conv_strobe_o(conv_strobe_o),
  .mode_o(mode_o), .smp_valid_o(smp_valid_o), .smp_ready_i(smp_ready_i),
  .smp_a_o(smp_a_o), .ovr_o(ovr_o));

// File: tb/adc_frame_ctrl_tb.sv
module adc_frame_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, chan_sel = 1'b1, smp_ready_i = 1'b1;
  logic [7:0] div_sel = 8'd3;
  logic [1:0] cfg_mode = 2'd2;
  logic sdo_a = 1'b0, sdo_b = 1'b0;
  logic sclk_o, conv_strobe_o, addr_o, smp_valid_o, ovr_o;
  logic [1:0] mode_o, tag_a_o, tag_b_o;
  logic [15:0] smp_a_o, smp_b_o;

  always #5 clk = ~clk;

  adc_frame_ctrl dut_i (
    .clk(clk), .rst(rst), .en(en), .div_sel(div_sel), .cfg_mode(cfg_mode),
    .chan_sel(chan_sel), .sdo_a(sdo_a), .sdo_b(sdo_b), .sclk_o(sclk_o),
    .conv_strobe_o(conv_strobe_o), .addr_o(addr_o), .mode_o(mode_o),
    .smp_valid_o(smp_valid_o), .smp_ready_i(smp_ready_i), .smp_a_o(smp_a_o),
    .tag_a_o(tag_a_o), .smp_b_o(smp_b_o), .tag_b_o(tag_b_o), .ovr_o(ovr_o));

  int checks = 0, fails = 0;
  bit done = 0, mon_on = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference of the converter link
  int m_ph = 0, m_bit = 0, frm = 0, d, h, fb;
  bit m_run = 0, m_fresh = 0, m_skip = 0, m_sclk = 0, m_strb = 0, m_addr = 0;
  bit m_valid = 0, m_ovr = 0, wrap, emit;
  logic [1:0] m_mode = 0, m_ta = 0, m_tb = 0;
  logic [15:0] m_a = 0, m_b = 0;
  logic [17:0] wa = 0, wb = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_fresh = 0; m_skip = 0; m_sclk = 0; m_strb = 0; m_addr = 0;
      m_valid = 0; m_ovr = 0; m_mode = 0; m_ph = 0; m_bit = 0;
      m_a = 0; m_b = 0; m_ta = 0; m_tb = 0;
      sdo_a <= 1'b0; sdo_b <= 1'b0;
    end else begin
      d = (div_sel == 0) ? 1 : int'(div_sel);
      h = (d + 1) / 2;
      emit = 0;
      if (!m_run) begin
        if (en) begin m_run = 1; m_fresh = 1; m_ph = d; end
      end else if (m_ph == d) begin
        fb = m_mode[1] ? 20 : 32;
        wrap = m_fresh || (m_bit == fb);
        if (wrap && !en) m_run = 0;
        else begin
          if (wrap) begin
            m_skip = (cfg_mode == 2'd3) && (m_fresh || cfg_mode != m_mode);
            m_mode = cfg_mode;
            frm++;
            wa = {2'(frm), 16'(frm * 16'h3A5B) ^ 16'hC35A};
            wb = {~2'(frm), 16'(frm * 16'h1F07) ^ 16'h5AA5};
            m_bit = 0;
          end else m_bit++;
          m_fresh = 0; m_sclk = 1; m_ph = 0;
          m_strb = (m_bit < 3);
          m_addr = chan_sel && (m_bit < 4);
          if (m_bit >= 1 && m_bit <= 18) begin
            sdo_a <= wa[18 - m_bit];
            sdo_b <= wb[18 - m_bit];
          end else begin
            sdo_a <= frm[0]; sdo_b <= ~frm[0];
          end
        end
      end else begin
        if (m_ph == h - 1) begin
          m_sclk = 0;
          if (m_bit == 18 && !m_skip) emit = 1;
        end
        m_ph++;
      end
      if (emit) begin
        m_ovr = m_valid && !smp_ready_i;
        m_valid = 1;
        m_a = wa[15:0]; m_ta = wa[17:16];
        m_b = m_mode[1] ? 16'h0 : wb[15:0];
        m_tb = m_mode[1] ? 2'd0 : wb[17:16];
      end else begin
        m_ovr = 0;
        if (m_valid && smp_ready_i) m_valid = 0;
      end
    end
    mon_on = 1;
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (mon_on && !done) begin
      chk("R2 sclk_o", sclk_o, m_sclk);
      chk("R3 conv_strobe_o", conv_strobe_o, m_strb);
      chk("R5 addr_o", addr_o, m_addr);
      chk("R11 mode_o", mode_o, m_mode);
      chk("R6 smp_valid_o", smp_valid_o, m_valid);
      chk("R9 ovr_o", ovr_o, m_ovr);
      if (m_valid) begin
        chk("R6 smp_a_o", smp_a_o, m_a);
        chk("R6 tag_a_o", tag_a_o, m_ta);
        chk("R7 smp_b_o", smp_b_o, m_b);
        chk("R7 tag_b_o", tag_b_o, m_tb);
      end
    end
  end

  task automatic wait_strobe();
    logic p;
    p = conv_strobe_o;
    forever begin
      @(negedge clk);
      if (conv_strobe_o && !p) break;
      p = conv_strobe_o;
    end
  endtask

  task automatic span(output int rises, output int vals, output int ovrs);
    logic ps, pv, pst;
    rises = 0; vals = 0; ovrs = 0;
    ps = sclk_o; pv = smp_valid_o; pst = conv_strobe_o;
    forever begin
      @(negedge clk);
      if (sclk_o && !ps) rises++;
      if (smp_valid_o && !pv) vals++;
      if (ovr_o) ovrs++;
      if (conv_strobe_o && !pst) break;
      ps = sclk_o; pv = smp_valid_o; pst = conv_strobe_o;
    end
  endtask

  task automatic idle_check(input string req);
    int r;
    logic ps;
    r = 0;
    repeat (300) @(negedge clk);
    ps = sclk_o;
    repeat (100) begin
      @(negedge clk);
      if ((sclk_o && !ps) || conv_strobe_o) r++;
      ps = sclk_o;
    end
    chk(req, r, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    fails++;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int r, v, o, vs, os;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 sclk_o", sclk_o, 0);
    chk("R1 conv_strobe_o", conv_strobe_o, 0);
    chk("R1 smp_valid_o", smp_valid_o, 0);
    chk("R1 mode_o", mode_o, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {sclk_o, conv_strobe_o, addr_o, smp_valid_o, ovr_o}, 0);
    en = 1'b1;
    // single-line two-channel, divide by 4
    wait_strobe();
    span(r, v, o);
    chk("R4 single frame period", r, 21);
    chk("R6 one sample per frame", v, 1);
    chan_sel = 1'b0;
    span(r, v, o);
    span(r, v, o);
    chk("R5 frame period with chan 0", r, 21);
    // R10: drop enable mid frame
    repeat (30) @(negedge clk);
    en = 1'b0;
    idle_check("R10 idle after stop");
    // dual mode, divider 0 clamps to 1
    div_sel = 8'd0; cfg_mode = 2'd0; chan_sel = 1'b1; en = 1'b1;
    wait_strobe();
    span(r, v, o);
    chk("R4 dual frame period", r, 33);
    chk("R7 dual sample per frame", v, 1);
    cfg_mode = 2'd1;
    span(r, v, o);
    span(r, v, o);
    en = 1'b0;
    idle_check("R10 idle after dual");
    // four-channel sequential, odd divider
    div_sel = 8'd2; cfg_mode = 2'd3; en = 1'b1;
    wait_strobe();
    span(r, v, o);
    chk("R8 first frame discarded", v, 0);
    span(r, v, o);
    chk("R8 second frame delivers", v, 1);
    // R9: withhold ready across three frames
    smp_ready_i = 1'b0;
    vs = 0; os = 0;
    repeat (3) begin
      span(r, v, o);
      vs += v; os += o;
    end
    chk("R9 overrun count", os, 2);
    chk("R9 valid held", smp_valid_o, 1);
    smp_ready_i = 1'b1;
    span(r, v, o);
    // mode switch from 3 to 2 then back to 3 while running
    cfg_mode = 2'd2;
    span(r, v, o);
    cfg_mode = 2'd3;
    span(r, v, o);
    span(r, v, o);
    chk("R8 re-entry discards", v, 0);
    span(r, v, o);
    chk("R8 after re-entry delivers", v, 1);
    en = 1'b0;
    idle_check("R10 final idle");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule